// File: doc/BRIEF.md
# Match Cycle Sequencer

This block runs the digital side of a template-matching engine. The analog parts are outside the block: the charge-sharing DACs, the matching cells, the peak-current memories and the ramp comparators. A write cycle runs once after reset. It walks through every stored template and streams each one, bit by bit, into the per-element DACs. After that, each evaluate cycle takes one new input vector through two steps. First it streams the vector to the DACs. Then it raises an evaluate enable while a ramp code counts upward, so that the time-domain winner search can run.

All vector elements convert in parallel, one bit per clock, least significant bit first. A conversion therefore takes as many clocks as the element has bits. The ramp phase ends in one of two ways:

- The winner-found strobe arrives. The winner address is then captured.
- The last ramp step passes. The cycle then ends with a no-winner flag.

In both cases the result is held with a valid flag until the next accepted start. With the defaults, an unresolved evaluate cycle takes 8 conversion clocks plus 128 ramp clocks.

Top module: `match_cycle_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero and `tpl_loaded` is low.
- R2: A start pulse is acted on only when the sequencer is idle. A pulse during a write, a conversion, a ramp, or the cycle that closes an evaluation has no effect on timing or on the held result.
- R3: A start with `write_sel`=1 while `tpl_loaded` is low runs the write phase. The phase holds `wr_phase` high for NUM_TPL×ELEM_W clocks, with `tpl_idx` stepping from 0 every ELEM_W clocks. Then `tpl_loaded` rises and stays high. Later write requests are ignored, and evaluate requests made before loading are ignored.
- R4: In conversion clock k, counted from 0 in the clock after the start edge, `dac_strobe` is high. For each element e, `dac_bit[e]` equals bit k of element e, where element e occupies `vec_data[e*ELEM_W +: ELEM_W]`.
- R5: In an evaluate cycle, `eval_en` goes high in the clock after the last conversion clock. `ramp_code` starts at 0 there and increases by one each clock while `eval_en` is high.
- R6: If `winner_found` is high in a clock where `eval_en` is high, then in the next clock `eval_en` is low, `res_valid` is high, `res_nowin` is low, and `res_addr` holds the `winner_addr` sampled with it. This includes ramp step 0 and the last ramp step.
- R7: `winner_found` is ignored while `eval_en` is low. It has no effect during conversion or while idle.
- R8: With no winner, `eval_en` stays high for exactly RAMP_STEPS clocks. In the next clock `res_valid`=1, `res_nowin`=1 and `res_addr`=0.
- R9: `res_valid` and the result stay unchanged until an accepted start. That start clears `res_valid` at its clock edge.
- R10: Outside the write and conversion clocks, `dac_strobe` is low and `dac_bit` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request pulse |
| write_sel | input | 1 | 1 = write phase request, 0 = evaluate request |
| vec_data | input | NUM_ELEM*ELEM_W | Template (write) or input vector (evaluate), held stable while converting |
| winner_found | input | 1 | Global winner-found strobe |
| winner_addr | input | ADDR_W | Winner address from the search tree |
| dac_bit | output | NUM_ELEM | Current serial bit for each element DAC |
| dac_strobe | output | 1 | A DAC bit is presented this clock |
| wr_phase | output | 1 | Write phase active |
| tpl_idx | output | TPL_W | Template being written |
| eval_en | output | 1 | Ramp running and winner search enabled |
| ramp_code | output | RAMP_W | Ramp step code |
| res_valid | output | 1 | Result held |
| res_addr | output | ADDR_W | Latched winner address |
| res_nowin | output | 1 | Ramp ended without a winner |
| tpl_loaded | output | 1 | Templates have been written |

## Verification
Several input vector patterns are streamed through conversion, and each one exposes a different fault in the bit ordering:

- single set bits at the top or bottom of an element show whether the order is reversed;
- all-ones and all-zero vectors show stuck lanes;
- alternating patterns show swapped elements.

The ramp phase is tried with winners at a mid step, at step 0 and at the last step, and with no winner at all. This separates correct termination from off-by-one ramp ends and from a no-winner flag that wins over a real winner on the final step. Stray winner strobes and start pulses are injected during conversion, during the ramp, in the closing clock and while idle. Each is then shown to leave timing and the held result untouched.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRITE = 3'd1,
      ST_CONV  = 3'd2,
      ST_RAMP  = 3'd3,
      ST_DONE  = 3'd4
   } mcs_state_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mcs_counter.sv
module mcs_counter #(
   parameter int unsigned LIMIT = 8,
   localparam int unsigned W = mcs_pkg::idx_width(LIMIT)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic         at_end
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("mcs_counter: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_single
      assign cnt    = '0;
      assign at_end = 1'b1;
   end else if ((LIMIT & (LIMIT - 1)) == 0) begin : g_pow2
      // natural wrap at a power of two
      assign at_end = &cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt <= '0;
         else if (clr) cnt <= '0;
         else if (en)  cnt <= cnt + 1'b1;
      end
   end else begin : g_cmp
      assign at_end = (cnt == W'(LIMIT - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt <= '0;
         else if (clr) cnt <= '0;
         else if (en)  cnt <= at_end ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/mcs_bit_mux.sv
module mcs_bit_mux #(
   parameter int unsigned ELEM_W   = 8,
   parameter int unsigned NUM_ELEM = 4,
   localparam int unsigned SEL_W = $clog2(ELEM_W),
   localparam int unsigned VEC_W = NUM_ELEM * ELEM_W
) (
   input  logic [VEC_W-1:0]    vec,
   input  logic [SEL_W-1:0]    sel,
   input  logic                en,
   output logic [NUM_ELEM-1:0] bits
);

   for (genvar e = 0; e < NUM_ELEM; e++) begin : g_lane
      logic [ELEM_W-1:0] elem;
      assign elem    = vec[e*ELEM_W +: ELEM_W];
      assign bits[e] = en & elem[sel];
   end

endmodule

// File: rtl/match_cycle_seq.sv
module match_cycle_seq
   import mcs_pkg::*;
#(
   parameter int unsigned ELEM_W     = 8,
   parameter int unsigned NUM_ELEM   = 4,
   parameter int unsigned NUM_TPL    = 4,
   parameter int unsigned RAMP_STEPS = 128,
   parameter int unsigned ADDR_W     = 5,
   localparam int unsigned BIT_W  = $clog2(ELEM_W),
   localparam int unsigned TPL_W  = mcs_pkg::idx_width(NUM_TPL),
   localparam int unsigned RAMP_W = $clog2(RAMP_STEPS),
   localparam int unsigned VEC_W  = NUM_ELEM * ELEM_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                write_sel,
   input  logic [VEC_W-1:0]    vec_data,
   input  logic                winner_found,
   input  logic [ADDR_W-1:0]   winner_addr,
   output logic [NUM_ELEM-1:0] dac_bit,
   output logic                dac_strobe,
   output logic                wr_phase,
   output logic [TPL_W-1:0]    tpl_idx,
   output logic                eval_en,
   output logic [RAMP_W-1:0]   ramp_code,
   output logic                res_valid,
   output logic [ADDR_W-1:0]   res_addr,
   output logic                res_nowin,
   output logic                tpl_loaded
);

   // elaboration-time parameter checks
   if (ELEM_W < 2) begin : g_bad_elem
      $error("match_cycle_seq: ELEM_W must be at least 2");
   end
   if (RAMP_STEPS < 2) begin : g_bad_ramp
      $error("match_cycle_seq: RAMP_STEPS must be at least 2");
   end
   if (NUM_ELEM < 1 || NUM_TPL < 1 || ADDR_W < 1) begin : g_bad_count
      $error("match_cycle_seq: NUM_ELEM, NUM_TPL and ADDR_W must be non-zero");
   end

   mcs_state_t state_q, state_d;

   logic             is_idle, is_write, is_conv, is_ramp;
   logic             wr_go, ev_go;
   logic [BIT_W-1:0] bit_cnt;
   logic             bit_last, tpl_last, ramp_last;
   logic             loaded_q;

   assign is_idle  = (state_q == ST_IDLE);
   assign is_write = (state_q == ST_WRITE);
   assign is_conv  = (state_q == ST_CONV);
   assign is_ramp  = (state_q == ST_RAMP);

   // a write is taken only once, an evaluation only after loading
   assign wr_go = is_idle & start &  write_sel & ~loaded_q;
   assign ev_go = is_idle & start & ~write_sel &  loaded_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (wr_go)      state_d = ST_WRITE;
            else if (ev_go) state_d = ST_CONV;
         end
         ST_WRITE: if (bit_last && tpl_last) state_d = ST_IDLE;
         ST_CONV:  if (bit_last) state_d = ST_RAMP;
         ST_RAMP:  if (winner_found || ramp_last) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // serial bit position within the element
   mcs_counter #(.LIMIT(ELEM_W)) u_bit_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (wr_go | ev_go),
      .en     (is_write | is_conv),
      .cnt    (bit_cnt),
      .at_end (bit_last)
   );

   // template being downloaded
   mcs_counter #(.LIMIT(NUM_TPL)) u_tpl_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (wr_go),
      .en     (is_write & bit_last),
      .cnt    (tpl_idx),
      .at_end (tpl_last)
   );

   // ramp step generator
   mcs_counter #(.LIMIT(RAMP_STEPS)) u_ramp_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ev_go),
      .en     (is_ramp),
      .cnt    (ramp_code),
      .at_end (ramp_last)
   );

   mcs_bit_mux #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_bit_mux (
      .vec  (vec_data),
      .sel  (bit_cnt),
      .en   (dac_strobe),
      .bits (dac_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                loaded_q <= 1'b0;
      else if (is_write && bit_last && tpl_last) loaded_q <= 1'b1;
   end

   // result capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_addr  <= '0;
         res_nowin <= 1'b0;
      end else if (wr_go || ev_go) begin
         res_valid <= 1'b0;
      end else if (is_ramp && winner_found) begin
         res_valid <= 1'b1;
         res_addr  <= winner_addr;
         res_nowin <= 1'b0;
      end else if (is_ramp && ramp_last) begin
         res_valid <= 1'b1;
         res_addr  <= '0;
         res_nowin <= 1'b1;
      end
   end

   assign dac_strobe = is_write | is_conv;
   assign wr_phase   = is_write;
   assign eval_en    = is_ramp;
   assign tpl_loaded = loaded_q;

endmodule

// File: rtl/mcs_chk.sv
module mcs_chk #(
   parameter int unsigned NUM_ELEM   = 4,
   parameter int unsigned RAMP_STEPS = 128,
   parameter int unsigned ADDR_W     = 5,
   localparam int unsigned RAMP_W = $clog2(RAMP_STEPS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                winner_found,
   input logic [ADDR_W-1:0]   winner_addr,
   input logic [NUM_ELEM-1:0] dac_bit,
   input logic                dac_strobe,
   input logic                wr_phase,
   input logic                eval_en,
   input logic [RAMP_W-1:0]   ramp_code,
   input logic                res_valid,
   input logic [ADDR_W-1:0]   res_addr,
   input logic                res_nowin,
   input logic                tpl_loaded
);

   localparam logic [RAMP_W-1:0] LAST_STEP = RAMP_W'(RAMP_STEPS - 1);

   // R10
   dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_strobe |-> (dac_bit == '0));

   // R6
   win_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && winner_found) |=>
         (res_valid && !res_nowin && !eval_en && res_addr == $past(winner_addr)));

   // R5
   ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && !winner_found && ramp_code != LAST_STEP) |=>
         (eval_en && ramp_code == RAMP_W'($past(ramp_code) + 1'b1)));

   // R8
   no_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && !winner_found && ramp_code == LAST_STEP) |=>
         (res_valid && res_nowin && !eval_en && res_addr == '0));

   // R9
   hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!eval_en && !start) |=>
         ($stable(res_valid) && $stable(res_addr) && $stable(res_nowin)));

   // R3
   load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tpl_loaded |=> (tpl_loaded && !wr_phase));

   // R3
   load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tpl_loaded) |-> ($past(wr_phase) && !wr_phase));

endmodule

bind match_cycle_seq mcs_chk #(
   .NUM_ELEM   (NUM_ELEM),
   .RAMP_STEPS (RAMP_STEPS),
   .ADDR_W     (ADDR_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .winner_found (winner_found),
   .winner_addr  (winner_addr),
   .dac_bit      (dac_bit),
   .dac_strobe   (dac_strobe),
   .wr_phase     (wr_phase),
   .eval_en      (eval_en),
   .ramp_code    (ramp_code),
   .res_valid    (res_valid),
   .res_addr     (res_addr),
   .res_nowin    (res_nowin),
   .tpl_loaded   (tpl_loaded)
);

// File: tb/match_cycle_seq_tb.sv
module match_cycle_seq_tb_top;

   localparam int EW = 8;
   localparam int NE = 4;
   localparam int NT = 4;
   localparam int RS = 128;
   localparam int AW = 5;
   localparam int TW = 2;
   localparam int RW = 7;

   typedef struct packed {
      logic          nowin;
      logic [AW-1:0] addr;
   } res_t;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n;
   logic             start, write_sel, winner_found;
   logic [AW-1:0]    winner_addr;
   logic [NE*EW-1:0] in_vec, vec_data;
   logic [NE*EW-1:0] tpl_mem [NT];
   logic [NE-1:0]    dac_bit;
   logic             dac_strobe, wr_phase, eval_en, res_valid, res_nowin, tpl_loaded;
   logic [TW-1:0]    tpl_idx;
   logic [RW-1:0]    ramp_code;
   logic [AW-1:0]    res_addr;

   int   checks = 0;
   int   errors = 0;
   res_t exp_q[$];
   logic prev_v = 1'b0;

   // template memory read addressed by the sequencer
   assign vec_data = wr_phase ? tpl_mem[tpl_idx] : in_vec;

   match_cycle_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .write_sel(write_sel),
      .vec_data(vec_data), .winner_found(winner_found), .winner_addr(winner_addr),
      .dac_bit(dac_bit), .dac_strobe(dac_strobe), .wr_phase(wr_phase),
      .tpl_idx(tpl_idx), .eval_en(eval_en), .ramp_code(ramp_code),
      .res_valid(res_valid), .res_addr(res_addr), .res_nowin(res_nowin),
      .tpl_loaded(tpl_loaded)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [NE-1:0] lane_bits(input logic [NE*EW-1:0] v, input int k);
      logic [NE-1:0] b;
      for (int e = 0; e < NE; e++) b[e] = v[e*EW + k];
      return b;
   endfunction

   // monitor: compare each new result against the scoreboard
   always @(negedge clk) begin
      if (res_valid && !prev_v) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected result", {res_nowin, res_addr}, 0);
         end else begin
            res_t e;
            e = exp_q.pop_front();
            chk(res_nowin == e.nowin && res_addr == e.addr,
                e.nowin ? "R8 result" : "R6 result", {res_nowin, res_addr}, e);
         end
      end
      prev_v = res_valid;
   end

   task automatic do_write();
      start = 1'b1; write_sel = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < NT; t++) begin
         for (int k = 0; k < EW; k++) begin
            chk(wr_phase && dac_strobe && tpl_idx == t, "R3 write phase", {wr_phase, tpl_idx}, {1'b1, TW'(t)});
            chk(dac_bit == lane_bits(tpl_mem[t], k), "R4 write bits", dac_bit, lane_bits(tpl_mem[t], k));
            start = (t == 1 && k == 2);  // R2: ignored mid-write
            @(negedge clk);
            start = 1'b0;
         end
      end
      chk(!wr_phase && tpl_loaded && !dac_strobe, "R3 write end", {wr_phase, tpl_loaded, dac_strobe}, 3'b010);
   endtask

   // poke: 1 = stray winner during conversion (R7), 2 = start during ramp (R2),
   //       3 = start in the closing clock (R2)
   task automatic run_eval(input logic [NE*EW-1:0] v, input int win_step,
                           input logic [AW-1:0] addr, input int poke);
      res_t e;
      e.nowin = (win_step < 0);
      e.addr  = (win_step < 0) ? '0 : addr;
      exp_q.push_back(e);
      in_vec = v; write_sel = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!res_valid, "R9 cleared by start", res_valid, 0);
      for (int k = 0; k < EW; k++) begin
         chk(dac_strobe && !eval_en, "R4 strobe", {dac_strobe, eval_en}, 2'b10);
         chk(dac_bit == lane_bits(v, k), "R4 lsb-first bits", dac_bit, lane_bits(v, k));
         winner_found = (poke == 1 && k == 3);
         winner_addr  = 5'h1F;
         @(negedge clk);
         winner_found = 1'b0;
      end
      for (int r = 0; r < RS; r++) begin
         chk(eval_en && ramp_code == r, r == 0 ? "R5 ramp start" : (poke == 2 && r == 11) ? "R2 ramp kept" : "R5 ramp step",
             {eval_en, ramp_code}, {1'b1, RW'(r)});
         chk(!dac_strobe && dac_bit == '0, "R10 dac quiet", {dac_strobe, dac_bit}, 0);
         if (poke == 1 && r == 0) chk(!res_valid, "R7 conv winner ignored", res_valid, 0);
         start        = (poke == 2 && r == 10);
         winner_found = (r == win_step);
         winner_addr  = addr;
         @(negedge clk);
         start = 1'b0; winner_found = 1'b0;
         if (r == win_step) break;
      end
      chk(!eval_en && res_valid, win_step < 0 ? "R8 ramp end" : "R6 ramp stop",
          {eval_en, res_valid}, 2'b01);
      start = (poke == 3);
      @(negedge clk);
      start = 1'b0;
      chk(res_valid && !dac_strobe && !eval_en, "R2 closing-clock start ignored",
          {res_valid, dac_strobe, eval_en}, 3'b100);
   endtask

   initial begin
      for (int t = 0; t < NT; t++) tpl_mem[t] = 32'h3C96_A50F ^ (32'h1111_1111 * (t + 1));
      rst_n = 1'b0; start = 1'b0; write_sel = 1'b0; winner_found = 1'b0;
      winner_addr = '0; in_vec = '0;
      repeat (3) @(negedge clk);
      chk({dac_bit, dac_strobe, wr_phase, tpl_idx, eval_en, ramp_code, res_valid,
           res_addr, res_nowin, tpl_loaded} == '0, "R1 reset outputs",
          {dac_bit, dac_strobe, wr_phase, eval_en, res_valid, res_nowin, tpl_loaded}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!dac_strobe && !eval_en && !res_valid && !tpl_loaded, "R1 after reset",
          {dac_strobe, eval_en, res_valid, tpl_loaded}, 0);

      // evaluate before loading: ignored
      start = 1'b1; write_sel = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(!dac_strobe && !eval_en, "R3 eval before load ignored", {dac_strobe, eval_en}, 0);
      @(negedge clk);

      do_write();

      // second write request: ignored
      start = 1'b1; write_sel = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!wr_phase && !dac_strobe && tpl_loaded, "R3 rewrite ignored", {wr_phase, dac_strobe, tpl_loaded}, 3'b001);
      @(negedge clk);

      run_eval(32'h80_01_FF_00, 37, 5'd9, 1);

      // result held, winner strobe while idle ignored
      repeat (4) @(negedge clk);
      chk(res_valid && res_addr == 5'd9 && !res_nowin, "R9 result held", {res_valid, res_addr}, {1'b1, 5'd9});
      winner_found = 1'b1; winner_addr = 5'd3;
      @(negedge clk);
      winner_found = 1'b0;
      @(negedge clk);
      chk(res_valid && res_addr == 5'd9, "R7 idle winner ignored", res_addr, 5'd9);

      run_eval(32'hA5_5A_C3_3C, -1, 5'd0, 2);
      run_eval(32'h01_02_40_80, 0, 5'd1, 3);
      run_eval(32'hFF_FF_FF_FF, RS - 1, 5'd31, 0);
      run_eval(32'h00_00_00_00, 64, 5'd17, 0);

      @(negedge clk);
      chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule